// File: doc/BRIEF.md
# Expanded Data RAM Access Decoder

This block sits between a CPU's external-data-space access port and two possible targets: a small expanded RAM on the die and the slow multiplexed external bus. It looks at each access request and decides which target should take it. Three things drive that decision: the addressing style of the request, a software-chosen visible RAM window and an override bit that sends every access off-chip. When the request goes to the on-chip RAM, the access takes one clock and the external strobes stay quiet. When the request goes off-chip, the block drives an active-low read or write strobe for a fixed number of clocks and presents the high address byte. For a read, it samples the bus data as the strobe ends.

The visible window is a whole number of 256-byte pages. It is picked by a 2-bit field: the value plus one gives the page count, so the window runs from 256 to 1024 bytes. Any part of the array above the window is hidden, and accesses there go out to the bus instead. In short-address mode (register-indirect) the address has only an 8-bit offset, so it always falls in the first page. Only the 16-bit pointer mode can reach the pages above it. A stretch bit lengthens the external strobe from 6 clocks to 30 clocks for slow peripherals.

Top module: `xram_access_decoder`

## Requirements
- R1: With `ext_sel` low, a request goes to on-chip RAM (`ram_sel` high in the request cycle) exactly when its effective address is below (`size_sel`+1)*256. Otherwise it goes to the external bus.
- R2: With `ext_sel` high, every request goes to the external bus and `ram_sel` stays low.
- R3: With `req_wide` low, only `req_addr[7:0]` forms the effective address and the upper byte is ignored. Such a request is therefore always on-chip when `ext_sel` is low.
- R4: An on-chip access leaves `rd_n`, `wr_n` high, `ext_req` low and `addr_hi` zero. It raises `done` in the cycle after the request, and a read returns the byte last written to that effective address.
- R5: With `stretch` low, an external access holds its strobe low for exactly 6 cycles.
- R6: With `stretch` high, an external access holds its strobe low for exactly 30 cycles.
- R7: A write (`req_write`=1) drives only `wr_n` and a read drives only `rd_n`. The two are never low together, and `ext_req` is high exactly while a strobe is low.
- R8: During a wide external access, `addr_hi` carries `req_addr[15:8]`. During a narrow one it carries zero. Whenever no strobe is active it is zero.
- R9: `busy` is high from the clock after an external request is accepted until the cycle in which `done` is high. Requests presented while `busy` is high are ignored.
- R10: `done` is a one-cycle pulse one clock after the strobe returns high. For a read, `rdata` then holds `ext_rdata` as sampled on the edge that released `rd_n`.
- R11: After reset, `rd_n` and `wr_n` are high and `busy`, `done`, `ext_req` and `addr_hi` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit pointer address, 0 = 8-bit register address |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| ext_sel | input | 1 | Force all accesses to the external bus |
| size_sel | input | 2 | Visible on-chip window, (value+1) pages of 256 bytes |
| stretch | input | 1 | Long external strobe (30 clocks instead of 6) |
| ext_rdata | input | 8 | Data returned by the external bus |
| ram_sel | output | 1 | Request cycle is routed to on-chip RAM |
| ext_req | output | 1 | External bus transfer in progress |
| rd_n | output | 1 | Active-low external read strobe |
| wr_n | output | 1 | Active-low external write strobe |
| addr_hi | output | 8 | High address byte for the external bus |
| busy | output | 1 | External access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Data of the most recent completed read |

## Verification
The checker assumes a few things about the inputs. Configuration inputs (`ext_sel`, `size_sel`, `stretch`) hold steady while a request is presented. A request lasts one cycle, and it may fall in a busy period, where it must be ignored. `ext_rdata` is stable at the edge that ends a read strobe. The stimulus drives every request for one cycle, shortly after a rising edge, with all configuration inputs set in the same step. It keeps `ext_rdata` constant through each external read. One request is deliberately placed inside an external strobe to show that it is dropped.

// File: rtl/xram_pkg.sv
package xram_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_STROBE = 2'd1,
        SEQ_TAIL   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              write;
        logic [7:0]        hi;
        logic              long_pulse;
    } ext_cmd_t;

    // Exclusive upper bound of the visible on-chip window.
    function automatic logic [ADDR_W:0] window_end(input int unsigned pages,
                                                   input int unsigned page_bytes);
        return (ADDR_W + 1)'(pages * page_bytes);
    endfunction

endpackage

// File: rtl/xram_route.sv
module xram_route
    import xram_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int PAGE_CNT   = 4,
    localparam int SZ_W      = $clog2(PAGE_CNT)
) (
    input  logic              wide,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ext_sel,
    input  logic [SZ_W-1:0]   size_sel,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              on_chip
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(PAGE_BYTES - 1);

    logic [ADDR_W:0] limit;

    always_comb begin
        eff_addr = wide ? addr : (addr & PAGE_MASK);
        limit    = window_end(int'(size_sel) + 1, PAGE_BYTES);
        on_chip  = !ext_sel && ({1'b0, eff_addr} < limit);
    end

endmodule

// File: rtl/xram_store.sv
module xram_store
    import xram_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
        if (re) begin
            rdata <= cells[addr];
        end
    end

endmodule

// File: rtl/xram_strobe_seq.sv
module xram_strobe_seq
    import xram_pkg::*;
#(
    parameter int SHORT_PULSE = 6,
    parameter int LONG_PULSE  = 30,
    localparam int CNT_W      = $clog2(LONG_PULSE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  ext_cmd_t          cmd,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ext_req,
    output logic [7:0]        addr_hi,
    output logic              busy,
    output logic              fin,
    output logic [DATA_W-1:0] cap_data
);
    seq_state_e       state;
    logic [CNT_W-1:0] cnt;

    assign busy = (state != SEQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            cnt      <= '0;
            rd_n     <= 1'b1;
            wr_n     <= 1'b1;
            ext_req  <= 1'b0;
            addr_hi  <= '0;
            fin      <= 1'b0;
            cap_data <= '0;
        end else begin
            fin <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state   <= SEQ_STROBE;
                        cnt     <= cmd.long_pulse ? CNT_W'(LONG_PULSE - 1)
                                                  : CNT_W'(SHORT_PULSE - 1);
                        rd_n    <= cmd.write;
                        wr_n    <= !cmd.write;
                        ext_req <= 1'b1;
                        addr_hi <= cmd.hi;
                    end
                end
                SEQ_STROBE: begin
                    if (cnt == '0) begin
                        if (!rd_n) begin
                            cap_data <= ext_rdata;
                        end
                        rd_n    <= 1'b1;
                        wr_n    <= 1'b1;
                        ext_req <= 1'b0;
                        addr_hi <= '0;
                        state   <= SEQ_TAIL;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SEQ_TAIL: begin
                    fin   <= 1'b1;
                    state <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xram_access_decoder.sv
module xram_access_decoder
    import xram_pkg::*;
#(
    parameter int PAGE_BYTES  = 256,
    parameter int PAGE_CNT    = 4,
    parameter int SHORT_PULSE = 6,
    parameter int LONG_PULSE  = 30,
    localparam int DEPTH      = PAGE_BYTES * PAGE_CNT,
    localparam int AW         = $clog2(DEPTH),
    localparam int SZ_W       = $clog2(PAGE_CNT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [15:0]       req_addr,
    input  logic [7:0]        req_wdata,
    input  logic              ext_sel,
    input  logic [SZ_W-1:0]   size_sel,
    input  logic              stretch,
    input  logic [7:0]        ext_rdata,
    output logic              ram_sel,
    output logic              ext_req,
    output logic              rd_n,
    output logic              wr_n,
    output logic [7:0]        addr_hi,
    output logic              busy,
    output logic              done,
    output logic [7:0]        rdata
);
    logic [ADDR_W-1:0] eff_addr;
    logic              on_chip;
    logic              accept, int_go, ext_go;
    logic              int_done;
    logic              last_src_int;
    logic              seq_fin;
    logic [DATA_W-1:0] store_rdata, cap_data;
    ext_cmd_t          cmd;

    xram_route #(
        .PAGE_BYTES(PAGE_BYTES),
        .PAGE_CNT  (PAGE_CNT)
    ) i_route (
        .wide    (req_wide),
        .addr    (req_addr),
        .ext_sel (ext_sel),
        .size_sel(size_sel),
        .eff_addr(eff_addr),
        .on_chip (on_chip)
    );

    assign accept  = req_valid && !busy;
    assign int_go  = accept && on_chip;
    assign ext_go  = accept && !on_chip;
    assign ram_sel = int_go;

    always_comb begin
        cmd.write      = req_write;
        cmd.hi         = req_wide ? req_addr[15:8] : 8'h00;
        cmd.long_pulse = stretch;
    end

    xram_store #(
        .DEPTH(DEPTH)
    ) i_store (
        .clk  (clk),
        .we   (int_go && req_write),
        .re   (int_go && !req_write),
        .addr (eff_addr[AW-1:0]),
        .wdata(req_wdata),
        .rdata(store_rdata)
    );

    xram_strobe_seq #(
        .SHORT_PULSE(SHORT_PULSE),
        .LONG_PULSE (LONG_PULSE)
    ) i_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (ext_go),
        .cmd      (cmd),
        .ext_rdata(ext_rdata),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .ext_req  (ext_req),
        .addr_hi  (addr_hi),
        .busy     (busy),
        .fin      (seq_fin),
        .cap_data (cap_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            int_done     <= 1'b0;
            last_src_int <= 1'b0;
        end else begin
            int_done <= int_go;
            if (accept && !req_write) begin
                last_src_int <= on_chip;
            end
        end
    end

    assign done  = int_done | seq_fin;
    assign rdata = last_src_int ? store_rdata : cap_data;

endmodule

// File: rtl/xram_access_checker.sv
module xram_access_checker #(
    parameter int SHORT_PULSE = 6,
    parameter int LONG_PULSE  = 30,
    localparam int CW         = $clog2(LONG_PULSE + 2)
) (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_wide,
    input logic       ext_sel,
    input logic       stretch,
    input logic       busy,
    input logic       ram_sel,
    input logic       ext_req,
    input logic       rd_n,
    input logic       wr_n,
    input logic [7:0] addr_hi,
    input logic       done
);
    logic          strobe_idle;
    logic [CW-1:0] low_cnt;
    logic          lat_long;

    assign strobe_idle = rd_n & wr_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= '0;
            lat_long <= 1'b0;
        end else begin
            low_cnt <= strobe_idle ? '0 : low_cnt + 1'b1;
            if (req_valid && !busy && !ram_sel) begin
                lat_long <= stretch;
            end
        end
    end

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n)); // R7

    AST_REQ_MATCHES_STROBE: assert property (@(posedge clk) disable iff (rst)
        ext_req == !strobe_idle); // R7

    AST_ONCHIP_QUIET: assert property (@(posedge clk) disable iff (rst)
        ram_sel |-> (strobe_idle && !ext_req && addr_hi == 8'h00)); // R4

    AST_OVERRIDE_EXTERNAL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ext_sel) |-> !ram_sel); // R2

    AST_NARROW_ONCHIP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !req_wide && !ext_sel) |-> ram_sel); // R3

    AST_HI_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        strobe_idle |-> (addr_hi == 8'h00)); // R8

    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (rst)
        !strobe_idle |-> busy); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_idle) |=> done); // R10

    AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_idle) |->
            (int'(low_cnt) == (lat_long ? LONG_PULSE : SHORT_PULSE))); // R5 R6

endmodule

bind xram_access_decoder xram_access_checker #(
    .SHORT_PULSE(SHORT_PULSE),
    .LONG_PULSE (LONG_PULSE)
) i_checker (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_wide (req_wide),
    .ext_sel  (ext_sel),
    .stretch  (stretch),
    .busy     (busy),
    .ram_sel  (ram_sel),
    .ext_req  (ext_req),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .addr_hi  (addr_hi),
    .done     (done)
);

// File: tb/test_xram_access_decoder.sv
`timescale 1ns/1ps
module test_xram_access_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_wide, ext_sel, stretch;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata, ext_rdata;
    logic [1:0]  size_sel;
    logic        ram_sel, ext_req, rd_n, wr_n, busy, done;
    logic [7:0]  addr_hi, rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    xram_access_decoder i_xram_access_decoder (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .ext_sel(ext_sel), .size_sel(size_sel), .stretch(stretch),
        .ext_rdata(ext_rdata), .ram_sel(ram_sel), .ext_req(ext_req),
        .rd_n(rd_n), .wr_n(wr_n), .addr_hi(addr_hi), .busy(busy),
        .done(done), .rdata(rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit mdl_onchip(input bit wide, input logic [15:0] a,
                                      input bit ext, input logic [1:0] sz);
        int ea;
        ea = wide ? int'(a) : int'(a) % 256;
        return !ext && (ea < (int'(sz) + 1) * 256);
    endfunction

    // Behavioural reference model, advanced on each rising edge.
    int         m_state;   // 0 idle, 1 strobing, 2 tail
    int         m_left;
    bit         m_read;
    logic       m_rd_n, m_wr_n, m_done;
    logic [7:0] m_hi, m_rdata;
    logic [7:0] m_mem [int];

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_left = 0; m_rd_n = 1; m_wr_n = 1;
            m_done = 0; m_hi = 0; m_rdata = 0;
        end else begin
            m_done = 0;
            if (m_state == 1) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    if (m_read) m_rdata = ext_rdata;
                    m_rd_n = 1; m_wr_n = 1; m_hi = 0; m_state = 2;
                end
            end else if (m_state == 2) begin
                m_done = 1; m_state = 0;
            end else if (req_valid) begin
                if (mdl_onchip(req_wide, req_addr, ext_sel, size_sel)) begin
                    int ea;
                    ea = req_wide ? int'(req_addr) : int'(req_addr) % 256;
                    if (req_write) m_mem[ea] = req_wdata;
                    else m_rdata = m_mem.exists(ea) ? m_mem[ea] : 8'hxx;
                    m_done = 1;
                end else begin
                    m_state = 1;
                    m_left  = stretch ? 30 : 6;
                    m_read  = !req_write;
                    m_rd_n  = req_write;
                    m_wr_n  = !req_write;
                    m_hi    = req_wide ? req_addr[15:8] : 8'h00;
                end
            end
        end
    end

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (!rst) begin
            bit exp_sel;
            exp_sel = req_valid && (m_state == 0) &&
                      mdl_onchip(req_wide, req_addr, ext_sel, size_sel);
            chk(ram_sel === exp_sel, "R1 ram_sel", ram_sel, exp_sel);
            chk(rd_n === m_rd_n, "R7 rd_n", rd_n, m_rd_n);
            chk(wr_n === m_wr_n, "R7 wr_n", wr_n, m_wr_n);
            chk(ext_req === !(m_rd_n && m_wr_n), "R7 ext_req", ext_req, !(m_rd_n && m_wr_n));
            chk(busy === (m_state != 0), "R9 busy", busy, m_state != 0);
            chk(done === m_done, "R10 done", done, m_done);
            chk(addr_hi === m_hi, "R8 addr_hi", addr_hi, m_hi);
            if (m_done && !$isunknown(m_rdata))
                chk(rdata === m_rdata, "R10 rdata", rdata, m_rdata);
        end
    end

    task automatic pulse(input bit wr, input bit wide, input logic [15:0] a,
                         input logic [7:0] d, input bit ext, input logic [1:0] sz,
                         input bit st);
        @(posedge clk); #2;
        req_valid = 1; req_write = wr; req_wide = wide; req_addr = a;
        req_wdata = d; ext_sel = ext; size_sel = sz; stretch = st;
        @(posedge clk); #2;
        req_valid = 0;
    endtask

    task automatic access(input bit wr, input bit wide, input logic [15:0] a,
                          input logic [7:0] d, input bit ext, input logic [1:0] sz,
                          input bit st, input bit exp_int, input int exp_len,
                          input logic [7:0] exp_rd, input string tag);
        int lows, other;
        bit seen;
        @(posedge clk); #2;
        req_valid = 1; req_write = wr; req_wide = wide; req_addr = a;
        req_wdata = d; ext_sel = ext; size_sel = sz; stretch = st;
        @(negedge clk);
        chk(ram_sel === exp_int, {tag, " routing"}, ram_sel, exp_int);
        @(posedge clk); #2;
        req_valid = 0;
        lows = 0; other = 0; seen = 0;
        for (int i = 0; i < 100 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
            else begin
                if (wr ? !wr_n : !rd_n) lows++;
                if (wr ? !rd_n : !wr_n) other++;
            end
        end
        chk(seen, {tag, " completion"}, seen, 1);
        chk(lows == exp_len, {tag, " strobe length"}, lows, exp_len);
        chk(other == 0, "R7 opposite strobe", other, 0);
        if (!wr) chk(rdata === exp_rd, {tag, " read data"}, rdata, exp_rd);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1; req_valid = 0; req_write = 0; req_wide = 0; req_addr = 0;
        req_wdata = 0; ext_sel = 0; size_sel = 0; stretch = 0; ext_rdata = 8'h3C;
        repeat (3) @(posedge clk);
        #2 rst = 0;
        @(negedge clk);
        chk(rd_n === 1 && wr_n === 1, "R11 strobes idle", {rd_n, wr_n}, 3);
        chk(busy === 0 && done === 0 && ext_req === 0, "R11 status low",
            {busy, done, ext_req}, 0);
        chk(addr_hi === 8'h00, "R11 addr_hi", addr_hi, 0);

        // On-chip write then read back (R1, R4)
        access(1, 1, 16'h0010, 8'hA5, 0, 2'd0, 0, 1, 0, 8'h00, "R1 low page write");
        access(0, 1, 16'h0010, 8'h00, 0, 2'd0, 0, 1, 0, 8'hA5, "R4 on-chip read");
        // Window boundaries for each size (R1)
        access(0, 1, 16'h0150, 8'h00, 0, 2'd0, 0, 0, 6, 8'h3C, "R1 above 256 window");
        access(1, 1, 16'h0150, 8'h5A, 0, 2'd1, 0, 1, 0, 8'h00, "R1 inside 512 window");
        access(1, 1, 16'h01FF, 8'h61, 0, 2'd1, 0, 1, 0, 8'h00, "R1 last byte of 512");
        access(1, 1, 16'h0200, 8'h62, 0, 2'd1, 0, 0, 6, 8'h00, "R1 first byte past 512");
        access(1, 1, 16'h02FF, 8'h63, 0, 2'd2, 0, 1, 0, 8'h00, "R1 last byte of 768");
        access(1, 1, 16'h03FF, 8'h64, 0, 2'd3, 0, 1, 0, 8'h00, "R1 last byte of 1024");
        access(0, 1, 16'h03FF, 8'h00, 0, 2'd3, 0, 1, 0, 8'h64, "R4 top read back");
        ext_rdata = 8'h9E;
        access(0, 1, 16'h0400, 8'h00, 0, 2'd3, 0, 0, 6, 8'h9E, "R5 past 1024 short read");
        // Override (R2)
        ext_rdata = 8'h47;
        access(0, 1, 16'h0010, 8'h00, 1, 2'd3, 0, 0, 6, 8'h47, "R2 override read");
        access(1, 0, 16'h0005, 8'h11, 1, 2'd0, 0, 0, 6, 8'h00, "R2 override narrow write");
        // Narrow addressing ignores the high byte (R3)
        access(1, 0, 16'h0350, 8'hC7, 0, 2'd0, 0, 1, 0, 8'h00, "R3 narrow write");
        access(0, 1, 16'h0050, 8'h00, 0, 2'd0, 0, 1, 0, 8'hC7, "R3 wide read of page 0");
        // Stretched strobe and data capture (R6, R10)
        ext_rdata = 8'hD2;
        access(0, 1, 16'h8123, 8'h00, 0, 2'd0, 1, 0, 30, 8'hD2, "R6 long read");
        access(1, 1, 16'hF000, 8'h33, 0, 2'd3, 1, 0, 30, 8'h00, "R6 long write");

        // High byte during wide and narrow external access (R8)
        pulse(1, 1, 16'hAB12, 8'h01, 1, 2'd0, 0);
        @(negedge clk);
        chk(addr_hi === 8'hAB, "R8 wide high byte", addr_hi, 8'hAB);
        wait (done === 1); @(negedge clk);
        pulse(1, 0, 16'hAB12, 8'h01, 1, 2'd0, 0);
        @(negedge clk);
        chk(addr_hi === 8'h00, "R8 narrow high byte", addr_hi, 0);
        wait (done === 1); @(negedge clk);

        // Request during busy is dropped (R9)
        access(1, 1, 16'h0020, 8'h11, 0, 2'd0, 0, 1, 0, 8'h00, "R9 seed write");
        pulse(0, 1, 16'h0300, 8'h00, 0, 2'd0, 0);
        repeat (2) @(posedge clk);
        #2;
        req_valid = 1; req_write = 1; req_wide = 1; req_addr = 16'h0020;
        req_wdata = 8'h77; ext_sel = 0; size_sel = 0;
        @(negedge clk);
        chk(ram_sel === 0, "R9 busy request not routed", ram_sel, 0);
        @(posedge clk); #2 req_valid = 0;
        wait (done === 1); @(negedge clk);
        access(0, 1, 16'h0020, 8'h00, 0, 2'd0, 0, 1, 0, 8'h11, "R9 dropped write");

        repeat (3) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule